// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block gathers the data bytes of one write transaction into a small page latch in front of a 128 x 8 storage array. A transaction opens with a start strobe that carries a 7-bit word address. The upper five bits pick the page and stay fixed for the whole transaction. The lower two bits give the first slot, and the slot pointer advances by one after every byte, wrapping inside the page. If more than four bytes arrive, the later ones overwrite the earlier ones.

When a stop strobe closes a transaction that holds at least one byte, the block enters a self-timed busy window. During that window it drains the written slots into the array, one per clock, in ascending slot order, and then waits until a fixed number of clock cycles has passed since the stop. All strobes are ignored while busy. An abort, or a fresh start arriving before the stop, throws away whatever is latched. Bus protocol decoding belongs to a neighbouring block.

Top module: `pwb_page_commit`

## Requirements
- R1: After reset, `busy` and `arr_we` are low.
- R2: A start strobe loads the page from `start_addr[6:2]` and the slot pointer from `start_addr[1:0]`. The first byte lands at `{page, start_addr[1:0]}`.
- R3: After each accepted byte, only the 2-bit slot pointer advances, modulo 4. Every array write of one commit carries the page bits loaded at the start.
- R4: When one slot receives several bytes, the commit writes it once, with the last byte it received. Slots never written are not written to the array.
- R5: A stop that finds at least one latched byte raises `busy` on the next cycle. From that cycle, `arr_we` is high for exactly as many consecutive cycles as there are written slots, presenting them in ascending slot order.
- R6: A stop with no latched byte leaves `busy` and `arr_we` low.
- R7: `busy` stays high for exactly `BUSY_CYC` consecutive cycles per commit.
- R8: While `busy` is high, all strobes are ignored: no byte, start, stop or abort changes the latch, the pointer or the page. After a commit the latch is empty, so a following bare stop commits nothing.
- R9: A start or an abort seen before the stop discards all latched bytes.
- R10: A byte and a stop in the same cycle: the byte is latched and included in that commit.
- R11: Priority within one cycle is abort, then start, then byte/stop. An abort cancels a simultaneous start. A start causes a simultaneous byte and stop to be ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronized on release |
| txn_start | input | 1 | Opens a transaction at `start_addr` |
| start_addr | input | 7 | Word address of the first byte |
| byte_vld | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte |
| txn_stop | input | 1 | Closes the transaction; commits if bytes are latched |
| txn_abort | input | 1 | Discards the latched page |
| busy | output | 1 | Commit window active; inputs locked |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 7 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The closing byte and the stop can arrive in the same cycle, and they then race for the latch. The bench provokes this both with a directed case and through random transactions whose last byte shares its cycle with the stop. It judges the result by whether that byte appears, at its slot address, in the drained write sequence that the bench model predicts. The same cycle-level collision is also driven between start and abort, and between start and byte, to check the ordering in R11.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic {
    ST_FILL = 1'b0,
    ST_BUSY = 1'b1
  } pwb_state_e;
endpackage

// File: rtl/pwb_slot_pick.sv
// Lowest-index set bit of the slot mask.
module pwb_slot_pick #(
  parameter int SLOT_W = 2,
  localparam int SLOTS = 1 << SLOT_W
) (
  input  logic [SLOTS-1:0]  mask,
  output logic [SLOT_W-1:0] idx,
  output logic              any
);
  always_comb begin
    idx = '0;
    any = |mask;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (mask[i]) idx = SLOT_W'(i);
    end
  end
endmodule

// File: rtl/pwb_page_latch.sv
// Page data slots, per-slot written mask and wrapping slot pointer.
module pwb_page_latch #(
  parameter int DATA_W = 8,
  parameter int SLOT_W = 2,
  localparam int SLOTS = 1 << SLOT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    discard,
  input  logic                    ptr_load,
  input  logic [SLOT_W-1:0]       ptr_init,
  input  logic                    byte_en,
  input  logic [DATA_W-1:0]       byte_in,
  input  logic                    retire_en,
  input  logic [SLOT_W-1:0]       retire_slot,
  output logic [SLOTS-1:0]        mask_q,
  output logic [SLOTS*DATA_W-1:0] slot_data
);
  logic [SLOT_W-1:0] ptr_q, ptr_d;
  logic [SLOTS-1:0]  mask_d;
  logic [SLOTS-1:0]  set_vec, clr_vec;

  always_comb begin
    set_vec = byte_en   ? (SLOTS'(1) << ptr_q)       : '0;
    clr_vec = retire_en ? (SLOTS'(1) << retire_slot) : '0;
    if (discard) mask_d = '0;
    else         mask_d = (mask_q | set_vec) & ~clr_vec;
    if (ptr_load)     ptr_d = ptr_init;
    else if (byte_en) ptr_d = ptr_q + 1'b1;
    else              ptr_d = ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ptr_q  <= '0;
    end else begin
      mask_q <= mask_d;
      ptr_q  <= ptr_d;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    logic              slot_en;
    assign slot_en = byte_en && (ptr_q == SLOT_W'(s));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q <= byte_in;
    end
    assign slot_data[s*DATA_W +: DATA_W] = slot_q;
  end
endmodule

// File: rtl/pwb_commit_timer.sv
// Down-counter that defines the busy window length.
module pwb_commit_timer #(
  parameter int BUSY_CYC = 625000,
  localparam int CNT_W = $clog2(BUSY_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)                     cnt_d = CNT_W'(BUSY_CYC - 1);
    else if (run && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = run && (cnt_q == '0);
endmodule

// File: rtl/pwb_page_commit.sv
// Page write buffer with self-timed commit into a word array.
module pwb_page_commit
  import pwb_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int SLOT_W   = 2,
  parameter int BUSY_CYC = 625000  // must be >= 2**SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              txn_stop,
  input  logic              txn_abort,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);
  localparam int PAGE_W = ADDR_W - SLOT_W;
  localparam int SLOTS  = 1 << SLOT_W;

  pwb_state_e state_q, state_d;
  logic [PAGE_W-1:0] page_q, page_d;

  logic fill, ev_abort, ev_start, ev_pass, ev_byte, ev_stop, commit_go;
  logic retire_en, expire, any_set;
  logic [SLOTS-1:0]        mask_q;
  logic [SLOTS*DATA_W-1:0] slot_data;
  logic [SLOT_W-1:0]       pick_idx;

  // Event decode with in-cycle priority: abort > start > byte/stop.
  always_comb begin
    fill      = (state_q == ST_FILL);
    ev_abort  = fill && txn_abort;
    ev_start  = fill && !txn_abort && txn_start;
    ev_pass   = fill && !txn_abort && !txn_start;
    ev_byte   = ev_pass && byte_vld;
    ev_stop   = ev_pass && txn_stop;
    commit_go = ev_stop && ((|mask_q) || ev_byte);
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_FILL: if (commit_go) state_d = ST_BUSY;
      ST_BUSY: if (expire)    state_d = ST_FILL;
      default: state_d = ST_FILL;
    endcase
    page_d = ev_start ? start_addr[ADDR_W-1:SLOT_W] : page_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FILL;
      page_q  <= '0;
    end else begin
      state_q <= state_d;
      page_q  <= page_d;
    end
  end

  pwb_page_latch #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .discard    (ev_abort || ev_start),
    .ptr_load   (ev_start),
    .ptr_init   (start_addr[SLOT_W-1:0]),
    .byte_en    (ev_byte),
    .byte_in    (byte_data),
    .retire_en  (retire_en),
    .retire_slot(pick_idx),
    .mask_q     (mask_q),
    .slot_data  (slot_data)
  );

  pwb_slot_pick #(.SLOT_W(SLOT_W)) u_pick (
    .mask(mask_q),
    .idx (pick_idx),
    .any (any_set)
  );

  pwb_commit_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (commit_go),
    .run   (state_q == ST_BUSY),
    .expire(expire)
  );

  assign retire_en = (state_q == ST_BUSY) && any_set;
  assign busy      = (state_q == ST_BUSY);
  assign arr_we    = retire_en;
  assign arr_addr  = {page_q, pick_idx};
  assign arr_wdata = slot_data[pick_idx*DATA_W +: DATA_W];
endmodule

// File: rtl/pwb_page_commit_chk.sv
module pwb_page_commit_chk #(
  parameter int ADDR_W   = 7,
  parameter int SLOT_W   = 2,
  parameter int BUSY_CYC = 625000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr
);
  localparam int CNT_W = $clog2(BUSY_CYC + 2);
  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  p_we_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  p_first_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> arr_we);

  p_busy_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_q < CNT_W'(BUSY_CYC));

  p_busy_exact_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_q == CNT_W'(BUSY_CYC));

  p_page_const_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |->
      arr_addr[ADDR_W-1:SLOT_W] == $past(arr_addr[ADDR_W-1:SLOT_W]));

  p_slot_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |->
      arr_addr[SLOT_W-1:0] > $past(arr_addr[SLOT_W-1:0]));
endmodule

bind pwb_page_commit pwb_page_commit_chk #(
  .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .BUSY_CYC(BUSY_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr)
);

// File: tb/pwb_page_commit_bench.sv
module pwb_page_commit_bench;
  localparam int BUSY = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, txn_start, byte_vld, txn_stop, txn_abort;
  logic [6:0] start_addr;
  logic [7:0] byte_data;
  logic       busy, arr_we;
  logic [6:0] arr_addr;
  logic [7:0] arr_wdata;

  pwb_page_commit #(.BUSY_CYC(BUSY)) u_pwb_page_commit (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .start_addr(start_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .txn_stop(txn_stop),
    .txn_abort(txn_abort), .busy(busy), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [4:0] m_page;
  logic [1:0] m_ptr;
  logic [3:0] m_mask;
  logic [7:0] m_data [4];
  logic [6:0] e_addr [$];
  logic [7:0] e_data [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit st, input logic [6:0] a, input bit v,
                       input logic [7:0] d, input bit sp, input bit ab);
    txn_start = st; start_addr = a; byte_vld = v;
    byte_data = d; txn_stop = sp; txn_abort = ab;
  endtask

  // Reference model of the requirements, priority abort > start > byte/stop.
  task automatic model_step(input bit st, input logic [6:0] a, input bit v,
                            input logic [7:0] d, input bit sp, input bit ab,
                            output bit go);
    go = 0;
    if (ab) m_mask = '0;
    else if (st) begin
      m_mask = '0; m_page = a[6:2]; m_ptr = a[1:0];
    end else begin
      if (v) begin
        m_data[m_ptr] = d; m_mask[m_ptr] = 1'b1; m_ptr = m_ptr + 2'd1;
      end
      if (sp && m_mask != 0) begin
        go = 1;
        e_addr.delete(); e_data.delete();
        for (int s = 0; s < 4; s++) begin
          if (m_mask[s]) begin
            e_addr.push_back({m_page, 2'(s)});
            e_data.push_back(m_data[s]);
          end
        end
        m_mask = '0;
      end
    end
  endtask

  task automatic check_commit(input string tag);
    int nb = 0;
    int nw = 0;
    for (int i = 0; i < BUSY + 2; i++) begin
      @(negedge clk);
      if (i == 0) chk(busy == 1'b1, {tag, " R5 busy rises after stop"}, busy, 1);
      if (busy) nb++;
      if (arr_we) begin
        if (nw < e_addr.size()) begin
          chk(i == nw, {tag, " R5 one write per clock"}, i, nw);
          chk(arr_addr == e_addr[nw], {tag, " R2 R3 write address"}, arr_addr, e_addr[nw]);
          chk(arr_wdata == e_data[nw], {tag, " R4 write data"}, arr_wdata, e_data[nw]);
        end else begin
          chk(1'b0, {tag, " R4 extra write"}, arr_addr, 0);
        end
        nw++;
      end
      // R8: random strobes while busy must be ignored
      if (i < BUSY) drive($urandom_range(1), 7'($urandom), $urandom_range(1),
                          8'($urandom), $urandom_range(1), $urandom_range(1));
      else drive(0, 0, 0, 0, 0, 0);
    end
    chk(nb == BUSY, {tag, " R7 busy length"}, nb, BUSY);
    chk(nw == e_addr.size(), {tag, " R5 write count"}, nw, e_addr.size());
  endtask

  task automatic step(input bit st, input logic [6:0] a, input bit v,
                      input logic [7:0] d, input bit sp, input bit ab,
                      input string tag);
    bit go;
    @(negedge clk);
    drive(st, a, v, d, sp, ab);
    @(posedge clk);
    model_step(st, a, v, d, sp, ab, go);
    if (go) check_commit(tag);
    else if (sp) begin
      @(negedge clk);
      drive(0, 0, 0, 0, 0, 0);
      chk(busy == 1'b0 && arr_we == 1'b0, {tag, " R6 no commit"}, {busy, arr_we}, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd11));
    drive(0, 0, 0, 0, 0, 0);
    m_page = '0; m_ptr = '0; m_mask = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(arr_we == 1'b0, "R1 arr_we after reset", arr_we, 0);
    rst_n = 1'b1;

    // R2 single byte
    step(1, 7'h25, 0, 0, 0, 0, "R2");
    step(0, 0, 1, 8'hA5, 0, 0, "R2");
    step(0, 0, 0, 0, 1, 0, "R2 single byte");
    // R3 wrap inside page: slots 2,3,0
    step(1, 7'h1E, 0, 0, 0, 0, "R3");
    for (int k = 0; k < 3; k++) step(0, 0, 1, 8'(8'h30 + k), 0, 0, "R3");
    step(0, 0, 0, 0, 1, 0, "R3 wrap");
    // R4 six bytes overwrite slots 0,1
    step(1, 7'h40, 0, 0, 0, 0, "R4");
    for (int k = 0; k < 6; k++) step(0, 0, 1, 8'(8'h60 + k), 0, 0, "R4");
    step(0, 0, 0, 0, 1, 0, "R4 overwrite");
    // R6 empty stop
    step(1, 7'h10, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 1, 0, "R6 empty");
    // R9 abort discards
    step(1, 7'h08, 0, 0, 0, 0, "R9");
    step(0, 0, 1, 8'h11, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 1, "R9");
    step(0, 0, 0, 0, 1, 0, "R9 abort");
    // R9 restart discards earlier bytes
    step(1, 7'h08, 0, 0, 0, 0, "R9");
    step(0, 0, 1, 8'h22, 0, 0, "R9");
    step(1, 7'h77, 0, 0, 0, 0, "R9");
    step(0, 0, 1, 8'h33, 0, 0, "R9");
    step(0, 0, 0, 0, 1, 0, "R9 restart");
    // R10 byte with stop
    step(1, 7'h52, 0, 0, 0, 0, "R10");
    step(0, 0, 1, 8'h44, 0, 0, "R10");
    step(0, 0, 1, 8'h45, 1, 0, "R10 byte with stop");
    // R8 bare stop after commit, then byte continues from the held pointer
    step(0, 0, 0, 0, 1, 0, "R8 stop after commit");
    step(0, 0, 1, 8'h99, 1, 0, "R8 pointer held");
    // R11 abort beats start; start beats byte and stop
    step(1, 7'h0C, 0, 0, 0, 0, "R11");
    step(0, 0, 1, 8'h55, 0, 0, "R11");
    step(1, 7'h3B, 0, 0, 0, 1, "R11");
    step(0, 0, 0, 0, 1, 0, "R11 abort wins");
    step(0, 0, 1, 8'h66, 0, 0, "R11");
    step(1, 7'h6A, 1, 8'h77, 1, 0, "R11 start wins");
    step(0, 0, 1, 8'h78, 1, 0, "R11 after start");

    // random transactions
    for (int t = 0; t < 40; t++) begin
      int nbytes;
      step(1, 7'($urandom), 0, 0, 0, 0, "R2 rand");
      nbytes = $urandom_range(7);
      for (int k = 0; k < nbytes; k++) begin
        bit last_with_stop;
        last_with_stop = (k == nbytes - 1) && ($urandom_range(1) == 1);
        if ($urandom_range(3) == 0) step(0, 0, 0, 0, 0, 0, "rand gap");
        step(0, 0, 1, 8'($urandom), last_with_stop, 0, "R10 rand");
        if (last_with_stop) nbytes = -1;
      end
      if (nbytes >= 0) begin
        if ($urandom_range(7) == 0) step(0, 0, 0, 0, 0, 1, "R9 rand");
        step(0, 0, 0, 0, 1, 0, "R5 rand");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule